// File: doc/BRIEF.md
# GPIO Port Register Bank with Change Interrupt

This block is the register core of an 8-bit general-purpose I/O expander. It holds three writable registers: pin direction, output level and read polarity. It also provides a read-only input register. It drives a per-pin output enable and output value toward the pads. It samples the pad levels through a two-flop synchronizer. When a pin that is configured as an input takes a level different from the one last captured, it pulls an active-low interrupt line.

A bus target, for example a serial slave, drives the host side. It presents a 2-bit register index, a write strobe with a data byte, and a read strobe. The read data appears on the cycle after the read strobe. A read of the input register captures the synchronized pin levels. That capture is what acknowledges the interrupt.

A small state machine sequences start-up. After reset it passes through SYNC_A and SYNC_B while the synchronizer fills. In LOAD it copies the first synchronized sample into the input register. It then stays in WATCH until the next reset. The transitions are SYNC_A to SYNC_B, SYNC_B to LOAD and LOAD to WATCH, one per clock, with no way back except reset. The interrupt is held inactive outside WATCH.

Top module: `gpio_regbank`

## Requirements
- R1: The direction register (index 3) resets to FFh. A 1 bit makes the pin an input, and `pin_oe` is the bitwise inverse of this register, so no pin is driven after reset.
- R2: The output register (index 1) resets to FFh, can be written and read back, and appears on `pin_out`. A pad only takes this level where `pin_oe` is 1.
- R3: The polarity register (index 2) resets to 00h and can be written and read back.
- R4: A read of index 0 returns the synchronized pin levels XOR the polarity register, so a polarity bit of 1 returns the inverted level. Writes to index 0 change no register.
- R5: Index encoding is 0 = input, 1 = output, 2 = polarity, 3 = direction. `rd_data` holds the selected value from the clock edge that samples `rd_en`.
- R6: `irq_n` goes low when any input-configured pin differs from the captured input register. It does so on the third rising edge after the pin change: two synchronizer stages plus the registered output.
- R7: A read of index 0 captures the synchronized pins, and `irq_n` returns high one clock after the read data appears, unless a pin changes again.
- R8: If a changed pin returns to its captured level before any read, `irq_n` returns high without a read.
- R9: Pins configured as outputs never cause `irq_n` to go low.
- R10: After reset release, the input register is loaded from the first synchronized sample, so static pin levels raise no interrupt.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_idx | input | 2 | Register index for reads and writes |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 8 | Write data |
| rd_en | input | 1 | Read strobe |
| rd_data | output | 8 | Read data, valid the cycle after `rd_en` |
| pin_in | input | 8 | Pad levels (asynchronous) |
| pin_oe | output | 8 | Per-pin output enable, 1 = driven |
| pin_out | output | 8 | Per-pin output value |
| irq_n | output | 1 | Change interrupt, active low (open-drain pull-down request) |

## Verification
The assertions assume that `pin_in` is stable around the sampling edge of the second synchronizer stage. They also assume `wr_en` and `rd_en` are never both meaningful for index 0 in ways that conflict. The bench meets this by changing pads and strobes only on falling clock edges. It also never raises `wr_en` and `rd_en` together. The bench models the pads as the output register where `pin_oe` is set and as its own external value elsewhere. This keeps the pin levels consistent with the direction register. It sweeps all 256 pin values under an uneven polarity mask, and all 256 values through the output and polarity registers. Each pin is then toggled alone to time the interrupt.

// File: rtl/gpio_pkg.sv
package gpio_pkg;
    localparam int unsigned PORT_W = 8;

    typedef enum logic [1:0] {
        IDX_IN  = 2'd0,
        IDX_OUT = 2'd1,
        IDX_POL = 2'd2,
        IDX_DIR = 2'd3
    } reg_idx_e;

    typedef enum logic [1:0] {
        ST_SYNC_A = 2'd0,
        ST_SYNC_B = 2'd1,
        ST_LOAD   = 2'd2,
        ST_WATCH  = 2'd3
    } chg_state_e;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
    parameter int unsigned WIDTH  = 8,
    parameter int unsigned STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_async,
    output logic [WIDTH-1:0] q_sync
);
    logic [WIDTH-1:0] chain_q [STAGES];

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        if (s == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain_q[s] <= '0;
                else        chain_q[s] <= d_async;
            end
        end else begin : g_rest
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain_q[s] <= '0;
                else        chain_q[s] <= chain_q[s-1];
            end
        end
    end

    assign q_sync = chain_q[STAGES-1];
endmodule

// File: rtl/gpio_chg.sv
module gpio_chg
    import gpio_pkg::*;
#(
    parameter int unsigned WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] pin_s,
    input  logic [WIDTH-1:0] dir_in,
    input  logic             capture,
    output logic [WIDTH-1:0] in_cap,
    output logic             watching,
    output logic             irq_n
);
    chg_state_e       state_q, state_d;
    logic [WIDTH-1:0] in_q;
    logic             irq_q;
    logic [WIDTH-1:0] diff;

    assign diff = (pin_s ^ in_q) & dir_in;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_SYNC_A: state_d = ST_SYNC_B;
            ST_SYNC_B: state_d = ST_LOAD;
            ST_LOAD:   state_d = ST_WATCH;
            ST_WATCH:  state_d = ST_WATCH;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_SYNC_A;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            in_q  <= '0;
            irq_q <= 1'b1;
        end else begin
            unique case (state_q)
                ST_SYNC_A, ST_SYNC_B: irq_q <= 1'b1;
                ST_LOAD: begin
                    in_q  <= pin_s;
                    irq_q <= 1'b1;
                end
                ST_WATCH: begin
                    if (capture) in_q <= pin_s;
                    irq_q <= ~(|diff);
                end
            endcase
        end
    end

    assign in_cap   = in_q;
    assign watching = (state_q == ST_WATCH);
    assign irq_n    = irq_q;

    AST_IRQ_QUIET_UNTIL_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_WATCH) |-> irq_n); // R10
    AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (capture && state_q == ST_WATCH) |=> (in_cap == $past(pin_s))); // R7
    AST_NO_IRQ_WITHOUT_DIFF: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_n |-> ($past((pin_s ^ in_q) & dir_in) != '0)); // R9
endmodule

// File: rtl/gpio_regbank.sv
module gpio_regbank
    import gpio_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        reg_idx,
    input  logic              wr_en,
    input  logic [PORT_W-1:0] wr_data,
    input  logic              rd_en,
    output logic [PORT_W-1:0] rd_data,
    input  logic [PORT_W-1:0] pin_in,
    output logic [PORT_W-1:0] pin_oe,
    output logic [PORT_W-1:0] pin_out,
    output logic              irq_n
);
    localparam int unsigned SYNC_STAGES = 2;

    logic [PORT_W-1:0] dir_q, out_q, pol_q, rd_q;
    logic [PORT_W-1:0] pin_s, in_cap;
    logic              watching;
    reg_idx_e          idx;

    assign idx = reg_idx_e'(reg_idx);

    gpio_sync #(.WIDTH(PORT_W), .STAGES(SYNC_STAGES)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .d_async(pin_in),
        .q_sync (pin_s)
    );

    gpio_chg #(.WIDTH(PORT_W)) u_chg (
        .clk     (clk),
        .rst_n   (rst_n),
        .pin_s   (pin_s),
        .dir_in  (dir_q),
        .capture (rd_en && idx == IDX_IN),
        .in_cap  (in_cap),
        .watching(watching),
        .irq_n   (irq_n)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dir_q <= '1;
            out_q <= '1;
            pol_q <= '0;
        end else if (wr_en) begin
            unique case (idx)
                IDX_IN:  ;
                IDX_OUT: out_q <= wr_data;
                IDX_POL: pol_q <= wr_data;
                IDX_DIR: dir_q <= wr_data;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_q <= '0;
        end else if (rd_en) begin
            unique case (idx)
                IDX_IN:  rd_q <= pin_s ^ pol_q;
                IDX_OUT: rd_q <= out_q;
                IDX_POL: rd_q <= pol_q;
                IDX_DIR: rd_q <= dir_q;
            endcase
        end
    end

    assign rd_data = rd_q;
    assign pin_oe  = ~dir_q;
    assign pin_out = out_q;

    AST_WRITE_INPUT_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && reg_idx == 2'd0) |=> ($stable(dir_q) && $stable(out_q) && $stable(pol_q))); // R4
    AST_READ_MATCHES_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && reg_idx == 2'd0 && watching) |=> (rd_data == (in_cap ^ $past(pol_q)))); // R4
endmodule

// File: tb/gpio_regbank_tb.sv
module gpio_regbank_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] reg_idx = 2'd0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic       rd_en = 1'b0;
    logic [7:0] rd_data, pin_oe, pin_out, pin_in;
    logic       irq_n;
    logic [7:0] ext = 8'h00;
    int         n_chk = 0;
    int         n_bad = 0;
    logic [7:0] v;

    always #4 clk = ~clk;

    assign pin_in = (pin_oe & pin_out) | (~pin_oe & ext);

    gpio_regbank u_dut (
        .clk(clk), .rst_n(rst_n), .reg_idx(reg_idx), .wr_en(wr_en),
        .wr_data(wr_data), .rd_en(rd_en), .rd_data(rd_data), .pin_in(pin_in),
        .pin_oe(pin_oe), .pin_out(pin_out), .irq_n(irq_n)
    );

    task automatic tick(input int n = 1);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            @(negedge clk);
        end
    endtask

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] idx, input logic [7:0] d);
        reg_idx = idx; wr_data = d; wr_en = 1'b1;
        tick();
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [1:0] idx, output logic [7:0] d);
        reg_idx = idx; rd_en = 1'b1;
        tick();
        d = rd_data;
        rd_en = 1'b0;
    endtask

    initial begin
        #(8 * 150000);
        n_chk++; n_bad++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        ext = 8'h5A;
        @(negedge clk); @(negedge clk);
        rst_n = 1'b1;
        tick(6);
        // reset state
        check("R1 pin_oe after reset", pin_oe, 8'h00);
        check("R10 no irq after reset with static pins", {7'd0, irq_n}, 8'h01);
        rd(2'd3, v); check("R1 direction reset", v, 8'hFF);
        rd(2'd1, v); check("R2 output reset", v, 8'hFF);
        rd(2'd2, v); check("R3 polarity reset", v, 8'h00);
        rd(2'd0, v); check("R5 input read index 0", v, 8'h5A);

        // R2/R3 sweeps through write and read back
        for (int k = 0; k < 256; k++) begin
            wr(2'd1, 8'(k));
            rd(2'd1, v); check("R2 output readback", v, 8'(k));
            check("R2 pin_out value", pin_out, 8'(k));
            wr(2'd2, 8'(255 - k));
            rd(2'd2, v); check("R3 polarity readback", v, 8'(255 - k));
        end

        // R4 input sweep with polarity mask
        wr(2'd2, 8'h3C);
        for (int k = 0; k < 256; k++) begin
            ext = 8'(k);
            tick(3);
            rd(2'd0, v); check("R4 input xor polarity", v, 8'(k) ^ 8'h3C);
        end
        wr(2'd2, 8'h00);
        tick(2);

        // R4 write to input index ignored
        wr(2'd0, 8'h00);
        rd(2'd1, v); check("R4 output unchanged by index 0 write", v, 8'hFF);
        rd(2'd2, v); check("R4 polarity unchanged by index 0 write", v, 8'h00);
        rd(2'd3, v); check("R4 direction unchanged by index 0 write", v, 8'hFF);
        rd(2'd0, v); check("R4 input still reflects pins", v, 8'hFF);

        // R1 direction mask
        wr(2'd1, 8'hA5);
        wr(2'd3, 8'h0F);
        check("R1 pin_oe follows direction", pin_oe, 8'hF0);
        check("R2 pin_out holds output", pin_out, 8'hA5);
        wr(2'd3, 8'hFF);
        tick(3);
        rd(2'd0, v);
        tick(2);
        check("R7 irq idle before sweep", {7'd0, irq_n}, 8'h01);

        // R6/R7 per-pin interrupt timing
        for (int b = 0; b < 8; b++) begin
            ext[b] = ~ext[b];
            tick(2);
            check("R6 irq not yet after two edges", {7'd0, irq_n}, 8'h01);
            tick(1);
            check("R6 irq low on third edge", {7'd0, irq_n}, 8'h00);
            rd(2'd0, v);
            check("R7 read returns new level", v, ext);
            check("R7 irq still low with read data", {7'd0, irq_n}, 8'h00);
            tick(1);
            check("R7 irq cleared after read", {7'd0, irq_n}, 8'h01);
        end

        // R8 change reverts before read
        ext[3] = ~ext[3];
        tick(3);
        check("R8 irq low after change", {7'd0, irq_n}, 8'h00);
        ext[3] = ~ext[3];
        tick(3);
        check("R8 irq high after revert", {7'd0, irq_n}, 8'h01);

        // R9 output pins do not interrupt
        wr(2'd3, 8'hFE);
        tick(4);
        wr(2'd1, 8'hFE);
        tick(4);
        check("R9 output pin toggle no irq", {7'd0, irq_n}, 8'h01);
        wr(2'd1, 8'hFF);
        tick(4);
        check("R9 output pin toggle back no irq", {7'd0, irq_n}, 8'h01);
        ext[2] = ~ext[2];
        tick(3);
        check("R9 input pin still interrupts", {7'd0, irq_n}, 8'h00);

        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule